// File: doc/BRIEF.md
# Serial Longest-Prefix Route Lookup

This block resolves an IPv4 destination address to a route inside one virtual router. Routes sit in a chain of small exact-match tables, one table per prefix length (/32, /24, /16, /8 and /0). A lookup probes the tables one per clock, longest length first, and stops at the first table that holds a matching entry. When no table matches, the result is a miss. Because the walk is driven by misses, a route with a shorter prefix is returned later than one with a longer prefix.

A hit returns one of two route kinds. A remote route gives an adjacency base index and a group size for the next-hop stage. A directly connected (local) route gives the egress router interface, for the local host lookup. Every entry has a match counter. A per-table enable input turns the counters of that table on or off. Routes are installed through a one-cycle write port. Only one lookup is in flight at a time. The request uses a valid/ready handshake, and the answer is a single-cycle response pulse.

The controller has three states. `WALK_IDLE` waits for a request. The *accept* transition goes to `WALK_PROBE` and resets the table index to 0. In `WALK_PROBE`, the *advance* transition moves to the next shorter table on a miss. The *finish* transition goes to `WALK_REPLY` on a hit, or after a miss in the /0 table. `WALK_REPLY` drives the response pulse, and its *release* transition returns to `WALK_IDLE`.

Top module: `lpm_walk_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and every table is empty, so any lookup misses.
- R2: An entry matches when it is valid, its virtual router id equals the request's id, and the request address masked to the table's prefix length equals the stored key. The key is masked when it is written, so address bits below the prefix length are ignored.
- R3: Tables are probed in the order /32, /24, /16, /8, /0, one per cycle. The first table with a match supplies the result, so the longest matching prefix wins.
- R4: Take the clock edge that accepts a request as edge 0. A hit in table index s (0 for /32 through 4 for /0) gives `resp_valid` high in the cycle after edge s+1. A miss gives it after edge 5.
- R5: `resp_valid` lasts exactly one cycle. `req_ready` is low from the accept edge until the cycle after the response pulse.
- R6: A remote hit reports `resp_local`=0, together with the adjacency base and group size stored with the entry.
- R7: A local hit reports `resp_local`=1 and the stored egress interface.
- R8: When a hit occurs and `cnt_en[s]` is 1 for the hit table, the entry's counter is incremented and `resp_count` shows the new value. When the bit is 0, the counter is left unchanged and reported as it is. Writing an entry clears its counter.
- R9: A miss reports `resp_hit`=0, and every other response field is 0.
- R10: A write encodes its table in `wr_sel`: 0=/32, 1=/24, 2=/16, 3=/8, 4=/0. `wr_valid`=0 removes the entry. A write is seen by any probe from the next cycle on. When two entries of one table match, the lower index wins.
- R11: A /0 entry matches every address that carries its virtual router id, so it acts as a default route.
- R12: `resp_plen` reports the prefix length of the table that hit (32, 24, 16, 8 or 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request will be accepted |
| req_vr | input | VR_W | Virtual router id of the request |
| req_addr | input | 32 | Destination address |
| cnt_en | input | 5 | Per-table counter enable, bit s for table s |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Target table (0=/32 .. 4=/0) |
| wr_idx | input | log2(ENTRIES) | Entry index within the table |
| wr_valid | input | 1 | Entry valid bit |
| wr_vr | input | VR_W | Entry virtual router id |
| wr_addr | input | 32 | Entry address (masked on write) |
| wr_local | input | 1 | Entry is a local route |
| wr_rif | input | 8 | Egress interface for a local route |
| wr_adj | input | 12 | Adjacency base index |
| wr_grp | input | 4 | Adjacency group size |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | A route matched |
| resp_local | output | 1 | Matched route is local |
| resp_plen | output | 6 | Matched prefix length |
| resp_rif | output | 8 | Egress interface |
| resp_adj | output | 12 | Adjacency base index |
| resp_grp | output | 4 | Adjacency group size |
| resp_count | output | CNT_W | Matched entry's counter after this hit |

## Verification
The response to a request is due s+1 cycles after its accept edge, where s is the index of the table that hits, and 5 cycles after it when every table misses. The driver reads the cycle number in the half-cycle after acceptance. It pushes that number plus the latency, which it takes from its own route model, into the scoreboard with the expected fields. The monitor samples on falling edges, so a pulse that arrives early, late or twice is caught as a latency or pulse failure and is not taken as a field mismatch.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int ADDR_W = 32;
    localparam int RIF_W  = 8;
    localparam int ADJ_W  = 12;
    localparam int GRP_W  = 4;

    typedef struct packed {
        logic             is_local;
        logic [RIF_W-1:0] rif;
        logic [ADJ_W-1:0] adj_base;
        logic [GRP_W-1:0] grp_size;
    } route_t;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_PROBE,
        WALK_REPLY
    } walk_state_e;

    // Mask keeping the top 'len' bits of an address.
    function automatic logic [ADDR_W-1:0] len_mask(input int len);
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i >= ADDR_W - len);
        end
        return m;
    endfunction
endpackage

// File: rtl/lpm_stage.sv
module lpm_stage
    import lpm_pkg::*;
#(
    parameter int VR_W    = 4,
    parameter int ENTRIES = 8,
    parameter int CNT_W   = 16,
    parameter int PLEN    = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [VR_W-1:0]   wr_vr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  route_t            wr_route,
    input  logic [VR_W-1:0]   q_vr,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic              count_en,
    output logic              hit,
    output route_t            hit_route,
    output logic [CNT_W-1:0]  hit_cnt
);
    localparam logic [ADDR_W-1:0] MASK = len_mask(PLEN);

    logic                ent_v   [ENTRIES];
    logic [VR_W-1:0]     ent_vr  [ENTRIES];
    logic [ADDR_W-1:0]   ent_key [ENTRIES];
    route_t              ent_rt  [ENTRIES];
    logic [CNT_W-1:0]    ent_cnt [ENTRIES];
    logic [ENTRIES-1:0]  match;
    logic [IDX_W-1:0]    hit_idx;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_v[e]   <= 1'b0;
                ent_vr[e]  <= '0;
                ent_key[e] <= '0;
                ent_rt[e]  <= '0;
                ent_cnt[e] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                ent_v[e]   <= wr_valid;
                ent_vr[e]  <= wr_vr;
                ent_key[e] <= wr_addr & MASK;
                ent_rt[e]  <= wr_route;
                ent_cnt[e] <= '0;
            end else if (count_en && hit && hit_idx == IDX_W'(e)) begin
                ent_cnt[e] <= ent_cnt[e] + 1'b1;
            end
        end

        assign match[e] = ent_v[e] && (ent_vr[e] == q_vr)
                          && ((q_addr & MASK) == ent_key[e]);
    end

    // Lowest matching index wins.
    always_comb begin
        hit_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match[e]) hit_idx = IDX_W'(e);
        end
    end

    assign hit       = |match;
    assign hit_route = ent_rt[hit_idx];
    assign hit_cnt   = ent_cnt[hit_idx];

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && hit && !(wr_en && wr_idx == hit_idx))
        |=> ent_cnt[$past(hit_idx)] == $past(hit_cnt) + 1'b1);

    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_v[$past(wr_idx)] == $past(wr_valid));
endmodule

// File: rtl/lpm_walk_ctrl.sv
module lpm_walk_ctrl
    import lpm_pkg::*;
#(
    parameter int NSTAGE  = 5,
    localparam int SIDX_W = $clog2(NSTAGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              stage_hit,
    output logic              req_ready,
    output logic              accept,
    output logic              probing,
    output logic              finish,
    output logic              resp_valid,
    output logic [SIDX_W-1:0] stage_idx
);
    walk_state_e       state_q, state_d;
    logic [SIDX_W-1:0] idx_q, idx_d;
    logic              last;

    assign last = (idx_q == SIDX_W'(NSTAGE - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Transitions: accept, advance, finish, release
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            WALK_IDLE: begin
                if (req_valid) begin
                    state_d = WALK_PROBE;
                    idx_d   = '0;
                end
            end
            WALK_PROBE: begin
                if (stage_hit || last) begin
                    state_d = WALK_REPLY;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            WALK_REPLY: begin
                state_d = WALK_IDLE;
            end
            default: state_d = WALK_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == WALK_IDLE);
        accept     = (state_q == WALK_IDLE) && req_valid;
        probing    = (state_q == WALK_PROBE);
        finish     = (state_q == WALK_PROBE) && (stage_hit || last);
        resp_valid = (state_q == WALK_REPLY);
        stage_idx  = idx_q;
    end

    assert_single_flight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_walk_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (probing && !stage_hit && !last) |=> (probing && stage_idx == $past(stage_idx) + 1'b1));

    assert_finish_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> resp_valid);
endmodule

// File: rtl/lpm_walk_engine.sv
module lpm_walk_engine
    import lpm_pkg::*;
#(
    parameter int VR_W    = 4,
    parameter int ENTRIES = 8,
    parameter int STEP    = 8,
    parameter int CNT_W   = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    output logic                                 req_ready,
    input  logic [VR_W-1:0]                      req_vr,
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic [ADDR_W/STEP:0]                 cnt_en,
    input  logic                                 wr_en,
    input  logic [$clog2(ADDR_W/STEP+1)-1:0]     wr_sel,
    input  logic [$clog2(ENTRIES)-1:0]           wr_idx,
    input  logic                                 wr_valid,
    input  logic [VR_W-1:0]                      wr_vr,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic                                 wr_local,
    input  logic [RIF_W-1:0]                     wr_rif,
    input  logic [ADJ_W-1:0]                     wr_adj,
    input  logic [GRP_W-1:0]                     wr_grp,
    output logic                                 resp_valid,
    output logic                                 resp_hit,
    output logic                                 resp_local,
    output logic [$clog2(ADDR_W+1)-1:0]          resp_plen,
    output logic [RIF_W-1:0]                     resp_rif,
    output logic [ADJ_W-1:0]                     resp_adj,
    output logic [GRP_W-1:0]                     resp_grp,
    output logic [CNT_W-1:0]                     resp_count
);
    localparam int NSTAGE = ADDR_W / STEP + 1;
    localparam int SIDX_W = $clog2(NSTAGE);
    localparam int PLEN_W = $clog2(ADDR_W + 1);

    logic              accept, probing, finish;
    logic [SIDX_W-1:0] stage_idx;
    logic [VR_W-1:0]   q_vr_q;
    logic [ADDR_W-1:0] q_addr_q;
    route_t            wr_route;

    logic [NSTAGE-1:0] st_hit;
    route_t            st_route [NSTAGE];
    logic [CNT_W-1:0]  st_cnt   [NSTAGE];

    logic              sel_hit, sel_en;
    route_t            sel_route;
    logic [CNT_W-1:0]  sel_cnt;
    logic [PLEN_W-1:0] sel_plen;

    logic              r_hit;
    route_t            r_route;
    logic [PLEN_W-1:0] r_plen;
    logic [CNT_W-1:0]  r_cnt;

    assign wr_route = '{is_local: wr_local, rif: wr_rif, adj_base: wr_adj, grp_size: wr_grp};

    lpm_walk_ctrl #(.NSTAGE(NSTAGE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .stage_hit  (sel_hit),
        .req_ready  (req_ready),
        .accept     (accept),
        .probing    (probing),
        .finish     (finish),
        .resp_valid (resp_valid),
        .stage_idx  (stage_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_vr_q   <= '0;
            q_addr_q <= '0;
        end else if (accept) begin
            q_vr_q   <= req_vr;
            q_addr_q <= req_addr;
        end
    end

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        logic st_wr, st_cnt_en;
        assign st_wr     = wr_en && (wr_sel == SIDX_W'(s));
        assign st_cnt_en = probing && (stage_idx == SIDX_W'(s)) && cnt_en[s];

        lpm_stage #(
            .VR_W    (VR_W),
            .ENTRIES (ENTRIES),
            .CNT_W   (CNT_W),
            .PLEN    (ADDR_W - s * STEP)
        ) u_tbl (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (st_wr),
            .wr_idx    (wr_idx),
            .wr_valid  (wr_valid),
            .wr_vr     (wr_vr),
            .wr_addr   (wr_addr),
            .wr_route  (wr_route),
            .q_vr      (q_vr_q),
            .q_addr    (q_addr_q),
            .count_en  (st_cnt_en),
            .hit       (st_hit[s]),
            .hit_route (st_route[s]),
            .hit_cnt   (st_cnt[s])
        );
    end

    // Select the table under probe
    always_comb begin
        sel_hit   = 1'b0;
        sel_en    = 1'b0;
        sel_route = '0;
        sel_cnt   = '0;
        sel_plen  = '0;
        for (int s = 0; s < NSTAGE; s++) begin
            if (stage_idx == SIDX_W'(s)) begin
                sel_hit   = st_hit[s];
                sel_en    = cnt_en[s];
                sel_route = st_route[s];
                sel_cnt   = st_cnt[s];
                sel_plen  = PLEN_W'(ADDR_W - s * STEP);
            end
        end
    end

    // Response register, loaded on finish
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_hit   <= 1'b0;
            r_route <= '0;
            r_plen  <= '0;
            r_cnt   <= '0;
        end else if (finish) begin
            r_hit <= sel_hit;
            if (sel_hit) begin
                r_route <= sel_route;
                r_plen  <= sel_plen;
                r_cnt   <= sel_cnt + (sel_en ? CNT_W'(1) : CNT_W'(0));
            end else begin
                r_route <= '0;
                r_plen  <= '0;
                r_cnt   <= '0;
            end
        end
    end

    assign resp_hit   = r_hit;
    assign resp_local = r_route.is_local;
    assign resp_rif   = r_route.rif;
    assign resp_adj   = r_route.adj_base;
    assign resp_grp   = r_route.grp_size;
    assign resp_plen  = r_plen;
    assign resp_count = r_cnt;

    assert_miss_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_plen == '0 && resp_count == '0 && !resp_local
                                       && resp_rif == '0 && resp_adj == '0 && resp_grp == '0));

    assert_no_req_taken_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);
endmodule

// File: tb/sim_lpm_walk_engine.sv
module sim_lpm_walk_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_vr = '0;
    logic [31:0] req_addr = '0;
    logic [4:0]  cnt_en = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [2:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_vr = '0;
    logic [31:0] wr_addr = '0;
    logic        wr_local = 1'b0;
    logic [7:0]  wr_rif = '0;
    logic [11:0] wr_adj = '0;
    logic [3:0]  wr_grp = '0;
    logic        resp_valid, resp_hit, resp_local;
    logic [5:0]  resp_plen;
    logic [7:0]  resp_rif;
    logic [11:0] resp_adj;
    logic [3:0]  resp_grp;
    logic [15:0] resp_count;

    lpm_walk_engine u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vr(req_vr), .req_addr(req_addr), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_vr(wr_vr),
        .wr_addr(wr_addr), .wr_local(wr_local), .wr_rif(wr_rif), .wr_adj(wr_adj),
        .wr_grp(wr_grp), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_local(resp_local), .resp_plen(resp_plen), .resp_rif(resp_rif),
        .resp_adj(resp_adj), .resp_grp(resp_grp), .resp_count(resp_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference route model
    bit          m_v   [5][8];
    int          m_vr  [5][8];
    logic [31:0] m_key [5][8];
    bit          m_loc [5][8];
    int          m_rif [5][8];
    int          m_adj [5][8];
    int          m_grp [5][8];
    int          m_cnt [5][8];

    function automatic logic [31:0] bmask(int len);
        return (len == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - len));
    endfunction

    typedef struct {
        bit     hit;
        bit     loc;
        int     plen;
        int     rif;
        int     adj;
        int     grp;
        int     cnt;
        longint due;
        string  tag;
    } exp_t;

    exp_t sb[$];

    task automatic do_write(int sel, int idx, bit v, int vr, logic [31:0] a,
                            bit loc, int rif, int adj, int grp);
        wr_en = 1; wr_sel = 3'(sel); wr_idx = 3'(idx); wr_valid = v;
        wr_vr = 4'(vr); wr_addr = a; wr_local = loc; wr_rif = 8'(rif);
        wr_adj = 12'(adj); wr_grp = 4'(grp);
        m_v[sel][idx] = v; m_vr[sel][idx] = vr;
        m_key[sel][idx] = a & bmask(32 - 8 * sel);
        m_loc[sel][idx] = loc; m_rif[sel][idx] = rif;
        m_adj[sel][idx] = adj; m_grp[sel][idx] = grp; m_cnt[sel][idx] = 0;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic lookup(int vr, logic [31:0] a, string tag);
        exp_t e;
        int   hs;
        int   hi;
        hs = -1; hi = -1;
        for (int s = 0; s < 5 && hs < 0; s++) begin
            for (int i = 0; i < 8 && hi < 0; i++) begin
                if (m_v[s][i] && m_vr[s][i] == vr && (a & bmask(32 - 8 * s)) == m_key[s][i]) begin
                    hs = s; hi = i;
                end
            end
        end
        e.tag = tag;
        if (hs >= 0) begin
            if (cnt_en[hs]) m_cnt[hs][hi]++;
            e.hit = 1; e.loc = m_loc[hs][hi]; e.plen = 32 - 8 * hs;
            e.rif = m_rif[hs][hi]; e.adj = m_adj[hs][hi]; e.grp = m_grp[hs][hi];
            e.cnt = m_cnt[hs][hi];
        end else begin
            e.hit = 0; e.loc = 0; e.plen = 0; e.rif = 0; e.adj = 0; e.grp = 0; e.cnt = 0;
        end
        req_vr = 4'(vr); req_addr = a; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, {"R5/", tag}, "ready after accept", req_ready, 0);
        e.due = cyc + ((hs >= 0) ? hs : 4) + 1;
        sb.push_back(e);
        do @(negedge clk); while (!req_ready);
    endtask

    // Monitor
    bit   prev_v = 0;
    exp_t me;
    always @(negedge clk) begin
        if (rst_n) begin
            if (resp_valid) begin
                if (prev_v) chk(0, "R5", "pulse longer than one cycle", 1, 0);
                if (sb.size() == 0) begin
                    chk(0, "R4", "unexpected response", 1, 0);
                end else begin
                    me = sb.pop_front();
                    chk(cyc == me.due, {"R4/", me.tag}, "response cycle", cyc, me.due);
                    chk(resp_hit == me.hit, {"R3/", me.tag}, "hit", resp_hit, me.hit);
                    chk(resp_plen == me.plen, {"R12/", me.tag}, "plen", resp_plen, me.plen);
                    chk(resp_local == me.loc, {"R7/", me.tag}, "local", resp_local, me.loc);
                    chk(resp_rif == me.rif, {"R7/", me.tag}, "rif", resp_rif, me.rif);
                    chk(resp_adj == me.adj, {"R6/", me.tag}, "adj", resp_adj, me.adj);
                    chk(resp_grp == me.grp, {"R6/", me.tag}, "grp", resp_grp, me.grp);
                    chk(resp_count == me.cnt, {"R8/", me.tag}, "count", resp_count, me.cnt);
                end
            end
            prev_v = resp_valid;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", "run did not finish", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 5; s++)
            for (int i = 0; i < 8; i++) m_v[s][i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
        chk(resp_valid == 0, "R1", "valid after reset", resp_valid, 0);
        lookup(1, 32'h0A01_0203, "R1_empty_R9");

        do_write(0, 0, 1, 1, 32'h0A01_0203, 0, 0, 100, 4);
        do_write(1, 2, 1, 1, 32'h0A01_024D, 1, 7, 0, 0);   // R2 low bits dropped
        do_write(2, 0, 1, 1, 32'h0A01_0000, 0, 0, 200, 2);
        do_write(3, 5, 1, 1, 32'h0A00_0000, 1, 3, 0, 0);
        do_write(4, 7, 1, 2, 32'h1234_5678, 0, 0, 300, 8); // R11 default for vr 2
        cnt_en = 5'b00011;

        lookup(1, 32'h0A01_0203, "R6_slash32");
        lookup(1, 32'h0A01_0203, "R8_again");
        lookup(1, 32'h0A01_0209, "R2_slash24_local");
        lookup(1, 32'h0A01_0909, "R8_disabled");
        lookup(1, 32'h0A01_0909, "R8_disabled_again");
        lookup(1, 32'h0AC8_0101, "R3_slash8");
        lookup(1, 32'h0B00_0001, "R9_miss");
        lookup(2, 32'h0A01_0203, "R11_default");
        lookup(3, 32'h0A01_0203, "R2_vr_mismatch");

        do_write(3, 1, 1, 1, 32'h0A09_0909, 0, 0, 55, 1);   // R10 lower index wins
        lookup(1, 32'h0AC8_0101, "R10_dup_low_index");
        do_write(0, 0, 0, 1, 32'h0A01_0203, 0, 0, 100, 4);  // R10 remove
        lookup(1, 32'h0A01_0203, "R10_removed");
        do_write(1, 2, 1, 1, 32'h0A01_0200, 1, 9, 0, 0);    // R8 write clears count
        lookup(1, 32'h0A01_02FF, "R8_cleared");
        cnt_en = 5'b11111;
        lookup(2, 32'hFFFF_FFFF, "R11_default_count");

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R4", "responses outstanding", sb.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule